// File: doc/BRIEF.md
# Serial Management Bus Command Frame Encoder

This block turns access, poll and terminate requests into the command frames a two-wire management bus master shifts out. An access request carries a direction, a 2-bit target id, a 21-bit byte address, a transfer size code and up to four bytes of write data. The encoder keeps a record of the last address that completed successfully. It uses that record to pick the shortest address form that still reaches the target: a repeat of the same word, a signed 9-bit offset, or the full 21-bit address. The transfer size is folded into the low address bits and a one-bit size flag. A 4-bit CRC follows, and it is seeded by an implied leading start bit.

A request is taken on a valid/ready handshake. One cycle later the finished frame appears left-aligned in a 64-bit word, with its length in bits. The frame stays there unchanged until the consumer takes it. The consumer reports the outcome of each access on a result strobe. A good result records the address of the access just encoded. A bad result forgets the stored address. A terminate frame or a break strobe also forgets it. A result that arrives in the same cycle as an accept is not seen by the frame being accepted.

Top module: `cfe_encoder`

## Requirements
- R1: The frame sends its fields in this order: id (2 bits), opcode, a direction bit (1 = read, 0 = write), the address field, a size flag, then for writes the data bytes, each 8 bits, with reqData[7:0] first. The opcodes are 3'b100 for absolute and 3'b101 for relative.
- R2: When the stored address is valid, holds the same id and holds the same word address (address bits 20:2) as the request, the encoder uses opcode 2'b11 and a 2-bit address field carrying address bits 1:0.
- R3: When the first case does not apply, the stored address is valid and holds the same id, and the request address minus the stored word-aligned address lies in -256..255, the encoder uses opcode 3'b101 and a 9-bit two's-complement offset.
- R4: In every other case the encoder uses opcode 3'b100 and the 21-bit address. This includes a different id and an offset of +256 or -257.
- R5: The size code is 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. For 1 byte the size flag is 0. For 2 bytes, bit 0 of the address field is forced to 0 and the flag is 1. For 4 bytes, bits 1:0 of the field are forced to 01 and the flag is 1.
- R6: The last 4 bits of the frame are a CRC with polynomial x^4+x+1 and initial value 0. It is computed over a 1 bit followed by every earlier frame bit, in order.
- R7: The first frame bit sits at bit 63 of frmWord, and frmBits gives the total length. All bits below the frame are 0.
- R8: reqKind is 1 for a data poll, 2 for an error poll and 3 for terminate. A data poll sends id plus 3'b010 plus CRC. An error poll sends id plus 3'b011 plus CRC. A terminate sends id plus 6'b111111 plus CRC.
- R9: After reset the stored address is invalid, so the first access is absolute. A good result stores the id and word address of the last encoded access. A bad result, an accepted terminate or a break makes the stored address invalid.
- R10: reqReady is high exactly when no frame is held. A held frame keeps frmValid, frmWord and frmBits unchanged until frmReady is seen, and the output empties on the cycle frmReady is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Encoder can take a request |
| reqKind | input | 2 | 0 access, 1 data poll, 2 error poll, 3 terminate |
| reqWrite | input | 1 | Access is a write |
| reqId | input | 2 | Target id |
| reqAddr | input | 21 | Byte address |
| reqSize | input | 2 | Size code (0:1 B, 1:2 B, 2/3:4 B) |
| reqData | input | 32 | Write data, first byte in bits 7:0 |
| frmValid | output | 1 | Frame held |
| frmReady | input | 1 | Consumer takes the frame |
| frmWord | output | 64 | Frame, left-aligned |
| frmBits | output | 7 | Frame length in bits |
| resultValid | input | 1 | Outcome of the last access frame |
| resultOk | input | 1 | Outcome was good |
| breakReq | input | 1 | Link break occurred |

## Verification
The hardest situations to reach are the edges of the relative window and the interplay between a pending access and the events that clear the stored address. Both depend on a history of results, not on the request in hand. The stimulus first stores a known base address. It then steps requests to offsets +255, +256, -256 and -257 from that base without reporting results, so the base stays fixed. Failed results, terminates and breaks are then placed between accesses, and a good result is sent after a terminate to show that the pending access is still recorded. A seeded run of mixed requests near the base, with results chosen at random, covers the rest. Each frame is checked against a bit-queue model.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  localparam int ID_W    = 2;
  localparam int ADDR_W  = 21;
  localparam int DATA_W  = 32;
  localparam int FRAME_W = 64;
  localparam int CNT_W   = $clog2(FRAME_W) + 1;
  localparam int CRC_W   = 4;
  localparam int WORD_W  = ADDR_W - 2;
  localparam int REL_SPAN = 256;
  localparam int REL_W   = $clog2(REL_SPAN) + 1;
  localparam int NBYTE_MAX = DATA_W / 8;

  localparam logic [2:0] OP_ABS   = 3'b100;
  localparam logic [2:0] OP_REL   = 3'b101;
  localparam logic [1:0] OP_SAME  = 2'b11;
  localparam logic [2:0] OP_DPOLL = 3'b010;
  localparam logic [2:0] OP_EPOLL = 3'b011;
  localparam logic [5:0] OP_TERM  = 6'b111111;
  localparam logic [CRC_W-1:0] CRC_POLY = 4'b0011;

  typedef enum logic [1:0] {
    KIND_ACCESS = 2'd0,
    KIND_DPOLL  = 2'd1,
    KIND_EPOLL  = 2'd2,
    KIND_TERM   = 2'd3
  } kind_e;

  typedef struct packed {
    logic load;
    logic commitLast;
    logic dropLast;
  } strobe_t;
endpackage

// File: rtl/cfe_ctrl.sv
module cfe_ctrl
  import cfe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       frmReady,
  input  logic       resultValid,
  input  logic       resultOk,
  input  logic       breakReq,
  output logic       reqReady,
  output logic       frmValid,
  output strobe_t    stb
);
  logic holdQ;
  logic pendQ;
  logic accept;

  assign reqReady = !holdQ;
  assign frmValid = holdQ;
  assign accept   = reqValid && !holdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      if (accept)        holdQ <= 1'b1;
      else if (frmReady) holdQ <= 1'b0;

      if (accept && (reqKind == KIND_ACCESS)) pendQ <= 1'b1;
      else if (resultValid)                   pendQ <= 1'b0;
    end
  end

  always_comb begin
    stb.load       = accept;
    stb.commitLast = resultValid && resultOk && pendQ;
    stb.dropLast   = (resultValid && !resultOk) || breakReq ||
                     (accept && (reqKind == KIND_TERM));
  end
endmodule

// File: rtl/cfe_datapath.sv
module cfe_datapath
  import cfe_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [1:0]         reqKind,
  input  logic               reqWrite,
  input  logic [ID_W-1:0]    reqId,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [1:0]         reqSize,
  input  logic [DATA_W-1:0]  reqData,
  output logic [FRAME_W-1:0] frmWord,
  output logic [CNT_W-1:0]   frmBits
);
  localparam logic signed [ADDR_W:0] REL_LO = (ADDR_W+1)'(-REL_SPAN);
  localparam logic signed [ADDR_W:0] REL_HI = (ADDR_W+1)'(REL_SPAN - 1);

  logic              lastValid;
  logic [ID_W-1:0]   lastId;
  logic [WORD_W-1:0] lastWord;
  logic [ID_W-1:0]   pendId;
  logic [WORD_W-1:0] pendWord;

  logic                   sameHit, relHit;
  logic signed [ADDR_W:0] diffS;
  logic [ADDR_W-1:0]      fieldVal;
  int                     fieldW;
  logic [2:0]             opVal;
  int                     opW;
  logic                   sizeFlag;
  int                     nBytes;
  logic [FRAME_W-1:0]     acc;
  int                     nAcc;
  logic [CRC_W-1:0]       crc;
  logic [FRAME_W-1:0]     fullWord;
  int                     total;

  function automatic logic [FRAME_W-1:0] shIn(logic [FRAME_W-1:0] a,
                                              logic [DATA_W-1:0] v, int w);
    logic [FRAME_W-1:0] mask;
    mask = (FRAME_W'(1) << w) - FRAME_W'(1);
    return (a << w) | ({{(FRAME_W-DATA_W){1'b0}}, v} & mask);
  endfunction

  // address form selection against the stored last address
  always_comb begin
    sameHit = lastValid && (lastId == reqId) && (lastWord == reqAddr[ADDR_W-1:2]);
    diffS   = $signed({1'b0, reqAddr}) - $signed({1'b0, lastWord, 2'b00});
    relHit  = lastValid && (lastId == reqId) && (diffS >= REL_LO) && (diffS <= REL_HI);
  end

  // address field, opcode and size folding
  always_comb begin
    if (sameHit) begin
      fieldVal = {{(ADDR_W-2){1'b0}}, reqAddr[1:0]};
      fieldW   = 2;
      opVal    = {1'b0, OP_SAME};
      opW      = 2;
    end else if (relHit) begin
      fieldVal = {{(ADDR_W-REL_W){1'b0}}, diffS[REL_W-1:0]};
      fieldW   = REL_W;
      opVal    = OP_REL;
      opW      = 3;
    end else begin
      fieldVal = reqAddr;
      fieldW   = ADDR_W;
      opVal    = OP_ABS;
      opW      = 3;
    end
    case (reqSize)
      2'd0: begin
        sizeFlag = 1'b0;
        nBytes   = 1;
      end
      2'd1: begin
        sizeFlag    = 1'b1;
        nBytes      = 2;
        fieldVal[0] = 1'b0;
      end
      default: begin
        sizeFlag      = 1'b1;
        nBytes        = NBYTE_MAX;
        fieldVal[1:0] = 2'b01;
      end
    endcase
  end

  // frame assembly, CRC and left alignment
  always_comb begin
    acc  = shIn('0, DATA_W'(reqId), ID_W);
    nAcc = ID_W;
    case (reqKind)
      KIND_ACCESS: begin
        acc  = shIn(acc, DATA_W'(opVal), opW);
        nAcc = nAcc + opW;
        acc  = shIn(acc, DATA_W'(!reqWrite), 1);
        nAcc = nAcc + 1;
        acc  = shIn(acc, DATA_W'(fieldVal), fieldW);
        nAcc = nAcc + fieldW;
        acc  = shIn(acc, DATA_W'(sizeFlag), 1);
        nAcc = nAcc + 1;
        for (int b = 0; b < NBYTE_MAX; b++) begin
          if (reqWrite && (b < nBytes)) begin
            acc  = shIn(acc, DATA_W'(reqData[8*b +: 8]), 8);
            nAcc = nAcc + 8;
          end
        end
      end
      KIND_DPOLL: begin
        acc  = shIn(acc, DATA_W'(OP_DPOLL), 3);
        nAcc = nAcc + 3;
      end
      KIND_EPOLL: begin
        acc  = shIn(acc, DATA_W'(OP_EPOLL), 3);
        nAcc = nAcc + 3;
      end
      default: begin
        acc  = shIn(acc, DATA_W'(OP_TERM), 6);
        nAcc = nAcc + 6;
      end
    endcase

    crc = CRC_POLY;  // state after the implied leading 1
    for (int i = FRAME_W - 1; i >= 0; i--) begin
      if (i < nAcc) begin
        if (crc[CRC_W-1] ^ acc[i]) crc = {crc[CRC_W-2:0], 1'b0} ^ CRC_POLY;
        else                       crc = {crc[CRC_W-2:0], 1'b0};
      end
    end
    total    = nAcc + CRC_W;
    fullWord = shIn(acc, DATA_W'(crc), CRC_W) << (FRAME_W - total);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frmWord   <= '0;
      frmBits   <= '0;
      lastValid <= 1'b0;
      lastId    <= '0;
      lastWord  <= '0;
      pendId    <= '0;
      pendWord  <= '0;
    end else begin
      if (stb.load) begin
        frmWord <= fullWord;
        frmBits <= CNT_W'(total);
        if (reqKind == KIND_ACCESS) begin
          pendId   <= reqId;
          pendWord <= reqAddr[ADDR_W-1:2];
        end
      end
      if (stb.dropLast) begin
        lastValid <= 1'b0;
      end else if (stb.commitLast) begin
        lastValid <= 1'b1;
        lastId    <= pendId;
        lastWord  <= pendWord;
      end
    end
  end
endmodule

// File: rtl/cfe_encoder.sv
module cfe_encoder
  import cfe_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [1:0]         reqKind,
  input  logic               reqWrite,
  input  logic [ID_W-1:0]    reqId,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [1:0]         reqSize,
  input  logic [DATA_W-1:0]  reqData,
  output logic               frmValid,
  input  logic               frmReady,
  output logic [FRAME_W-1:0] frmWord,
  output logic [CNT_W-1:0]   frmBits,
  input  logic               resultValid,
  input  logic               resultOk,
  input  logic               breakReq
);
  strobe_t stb;

  cfe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .frmReady(frmReady), .resultValid(resultValid), .resultOk(resultOk),
    .breakReq(breakReq), .reqReady(reqReady), .frmValid(frmValid), .stb(stb)
  );

  cfe_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqKind(reqKind), .reqWrite(reqWrite),
    .reqId(reqId), .reqAddr(reqAddr), .reqSize(reqSize), .reqData(reqData),
    .frmWord(frmWord), .frmBits(frmBits)
  );
endmodule

// File: rtl/cfe_checks.sv
module cfe_checks
  import cfe_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqReady,
  input logic [1:0]         reqKind,
  input logic               frmValid,
  input logic               frmReady,
  input logic [FRAME_W-1:0] frmWord,
  input logic [CNT_W-1:0]   frmBits
);
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && !frmReady) |=> (frmValid && $stable(frmWord) && $stable(frmBits)));

  assert_ready_when_empty_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady == !frmValid);

  assert_drain_R10: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && frmReady) |=> !frmValid);

  assert_length_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    frmValid |-> (frmBits >= CNT_W'(9) && frmBits <= CNT_W'(FRAME_W)));

  assert_tail_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    frmValid |-> ((frmWord << frmBits) == '0));

  assert_poll_length_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frmValid) |-> (($past(reqKind) == KIND_DPOLL || $past(reqKind) == KIND_EPOLL)
                         == (frmBits == CNT_W'(9))));

  assert_term_length_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(frmValid) && $past(reqKind) == KIND_TERM) |-> (frmBits == CNT_W'(12)));
endmodule

bind cfe_encoder cfe_checks u_checks (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqKind(reqKind), .frmValid(frmValid), .frmReady(frmReady),
  .frmWord(frmWord), .frmBits(frmBits)
);

// File: tb/cfe_encoder_test.sv
module cfe_encoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqKind = 2'd0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqId = 2'd0;
  logic [20:0] reqAddr = '0;
  logic [1:0]  reqSize = 2'd0;
  logic [31:0] reqData = '0;
  logic        frmValid;
  logic        frmReady = 1'b0;
  logic [63:0] frmWord;
  logic [6:0]  frmBits;
  logic        resultValid = 1'b0;
  logic        resultOk = 1'b0;
  logic        breakReq = 1'b0;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // reference state
  bit          expValid = 0;
  logic [63:0] expWord = '0;
  int          expBits = 0;
  string       curReq = "R10";
  bit          mLastValid = 0;
  int          mLastId = 0;
  int          mLastAddr = 0;
  bit          mPendValid = 0;
  int          mPendId = 0;
  int          mPendAddr = 0;

  always #4 clk = ~clk;

  cfe_encoder uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqWrite(reqWrite), .reqId(reqId), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqData(reqData), .frmValid(frmValid), .frmReady(frmReady),
    .frmWord(frmWord), .frmBits(frmBits), .resultValid(resultValid),
    .resultOk(resultOk), .breakReq(breakReq)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // compared on every clock, away from the edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(frmValid == expValid, "R10", "frmValid", frmValid, expValid);
      check(reqReady == !expValid, "R10", "reqReady", reqReady, !expValid);
      if (expValid) begin
        check(frmWord == expWord, curReq, "frmWord", frmWord, expWord);
        check(int'(frmBits) == expBits, curReq, "frmBits", frmBits, expBits);
      end
    end
  end

  function automatic void model(int kind, bit wr, int id, int addr, int sz,
                                logic [31:0] data, output logic [63:0] w, output int nb);
    bit q[$];
    int c;
    int fb;
    int nbytes;
    longint d;
    int fv, fw;
    q = {};
    for (int k = 1; k >= 0; k--) q.push_back(bit'((id >> k) & 1));
    if (kind == 0) begin
      nbytes = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      d = longint'(addr) - longint'(mLastAddr);
      if (mLastValid && mLastId == id && mLastAddr == (addr & ~3)) begin
        q.push_back(1); q.push_back(1);
        fv = addr & 3; fw = 2;
      end else if (mLastValid && mLastId == id && d >= -256 && d <= 255) begin
        q.push_back(1); q.push_back(0); q.push_back(1);
        fv = int'(d) & 'h1FF; fw = 9;
      end else begin
        q.push_back(1); q.push_back(0); q.push_back(0);
        fv = addr; fw = 21;
      end
      if (nbytes == 2) fv = fv & ~1;
      if (nbytes == 4) fv = (fv & ~3) | 1;
      q.push_back(!wr);
      for (int k = fw - 1; k >= 0; k--) q.push_back(bit'((fv >> k) & 1));
      q.push_back(nbytes > 1);
      if (wr)
        for (int b = 0; b < nbytes; b++)
          for (int k = 7; k >= 0; k--) q.push_back(data[8*b + k]);
    end else if (kind == 1) begin
      q.push_back(0); q.push_back(1); q.push_back(0);
    end else if (kind == 2) begin
      q.push_back(0); q.push_back(1); q.push_back(1);
    end else begin
      for (int k = 0; k < 6; k++) q.push_back(1);
    end
    c = 0;
    fb = 1;  // implied start bit
    c = ((c << 1) & 'hF) ^ (fb ? 3 : 0);
    foreach (q[i]) begin
      fb = ((c >> 3) & 1) ^ int'(q[i]);
      c = ((c << 1) & 'hF) ^ (fb ? 3 : 0);
    end
    for (int k = 3; k >= 0; k--) q.push_back(bit'((c >> k) & 1));
    w = '0;
    foreach (q[i]) w[63 - i] = q[i];
    nb = q.size();
  endfunction

  task automatic doReq(string req, int kind, bit wr, int id, int addr, int sz,
                       logic [31:0] data, int holdCycles);
    logic [63:0] w;
    int nb;
    model(kind, wr, id, addr, sz, data, w, nb);
    reqValid = 1; reqKind = 2'(kind); reqWrite = wr; reqId = 2'(id);
    reqAddr = 21'(addr); reqSize = 2'(sz); reqData = data;
    @(posedge clk); #1;
    reqValid = 0;
    expValid = 1; expWord = w; expBits = nb; curReq = req;
    if (kind == 0) begin mPendValid = 1; mPendId = id; mPendAddr = addr & ~3; end
    if (kind == 3) mLastValid = 0;
    for (int h = 0; h < holdCycles; h++) begin
      reqValid = 1;  // offered while full: must not be taken
      @(posedge clk); #1;
    end
    reqValid = 0;
    frmReady = 1;
    @(posedge clk); #1;
    frmReady = 0;
    expValid = 0;
  endtask

  task automatic result(bit ok);
    resultValid = 1; resultOk = ok;
    @(posedge clk); #1;
    resultValid = 0;
    if (ok && mPendValid) begin mLastValid = 1; mLastId = mPendId; mLastAddr = mPendAddr; end
    if (!ok) mLastValid = 0;
    mPendValid = 0;
  endtask

  task automatic doBreak();
    breakReq = 1;
    @(posedge clk); #1;
    breakReq = 0;
    mLastValid = 0;
  endtask

  initial begin
    int seed;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check(frmValid == 0, "R10", "reset frmValid", frmValid, 0);
    check(reqReady == 1, "R10", "reset reqReady", reqReady, 1);
    @(posedge clk); #1;

    // R9: first access after reset goes absolute
    doReq("R9", 0, 0, 0, 'h1000, 2, 32'h0, 0);
    result(1);
    // R2: same word, byte offsets; R5 size folding
    doReq("R2", 0, 0, 0, 'h1002, 0, 32'h0, 1);
    doReq("R5", 0, 1, 0, 'h1003, 1, 32'hBEEF, 0);
    doReq("R5", 0, 1, 0, 'h1002, 2, 32'h44332211, 2);
    // R3 / R4: relative window edges
    doReq("R3", 0, 0, 0, 'h10FF, 0, 32'h0, 0);
    doReq("R4", 0, 0, 0, 'h1100, 0, 32'h0, 0);
    doReq("R3", 0, 0, 0, 'h0F00, 0, 32'h0, 0);
    doReq("R4", 0, 0, 0, 'h0EFF, 0, 32'h0, 0);
    doReq("R4", 0, 0, 1, 'h1000, 0, 32'h0, 0);
    // R1 / R7: full-length absolute write, 64 bits
    doReq("R7", 0, 1, 2, 'h1FFFFC, 2, 32'hA5C3_0F96, 1);
    doReq("R1", 0, 1, 3, 'h000123, 0, 32'h5A, 0);
    // R9: bad result invalidates
    result(0);
    doReq("R9", 0, 0, 0, 'h1000, 0, 32'h0, 0);
    result(1);
    doReq("R9", 0, 0, 0, 'h1001, 0, 32'h0, 0);
    // R8 / R9: terminate invalidates, pending access still committed later
    doReq("R8", 3, 0, 0, 0, 0, 32'h0, 0);
    doReq("R9", 0, 0, 0, 'h1000, 0, 32'h0, 0);
    result(1);
    doReq("R9", 0, 0, 0, 'h1004, 1, 32'h0, 0);
    doBreak();
    doReq("R9", 0, 0, 0, 'h1004, 1, 32'h0, 0);
    // R8: polls and terminate for every id
    for (int i = 0; i < 4; i++) begin
      doReq("R8", 1, 0, i, 0, 0, 32'h0, 0);
      doReq("R8", 2, 0, i, 0, 0, 32'h0, 0);
      doReq("R8", 3, 0, i, 0, 0, 32'h0, 0);
    end
    // R6: mixed seeded traffic, CRC and forms across patterns
    doReq("R9", 0, 0, 1, 'h2000, 0, 32'h0, 0);
    result(1);
    seed = 32'h1D2C3B4A;
    for (int n = 0; n < 200; n++) begin
      int r;
      seed = seed * 1103515245 + 12345;
      r = seed >>> 8;
      doReq("R6", ((r & 7) == 0) ? ((r >> 3) & 3) : 0, (r >> 5) & 1,
            ((r >> 6) & 7) == 0 ? 0 : 1, 'h2000 + ((r >> 9) & 'h3FF) - 'h200,
            (r >> 19) & 3, 32'(seed * 7), (r >> 21) & 1);
      if (((r >> 22) & 3) != 0) result(((r >> 24) & 3) != 0);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule